// File: doc/BRIEF.md
# Half-to-single precision widening converter

This block takes a 16-bit IEEE-754 binary16 value and returns the 32-bit binary32 value that equals it exactly. Every binary16 value fits in binary32, so the block has no rounding mode and never loses information. Zeros, normal numbers, subnormal numbers, infinities and NaNs are all handled, and the sign bit always passes through unchanged.

Data enters and leaves on valid/ready streams with one register stage between them. A word is taken when `in_valid` and `in_ready` are both high at a rising clock edge. The converted word appears on the next cycle and stays there until it is taken by `out_valid` and `out_ready` at an edge. The input side is ready whenever the output register is empty or is being emptied in the same cycle. This gives full throughput with no bubble, and a stall downstream reaches the producer in the same cycle. Subnormal inputs are normalised in a single cycle: a priority encoder finds the leading one and a logarithmic shifter moves it.

Top module: `half_to_single_widen`

## Requirements
- R1: For a normal input (exponent field bits 14:10 neither 0 nor 31), the output exponent field (bits 30:23) is the input exponent plus 112. The output fraction (bits 22:0) is the 10-bit input fraction (bits 9:0) followed by 13 zero bits.
- R2: An input with exponent and fraction both zero gives an output of all zeros except bit 31, which equals input bit 15.
- R3: For a subnormal input (exponent 0, fraction nonzero) whose highest set fraction bit is at position p (0..9), the output exponent is 103+p. The output fraction is the input fraction shifted left by 10-p, with that leading one dropped, keeping the low 10 bits, and followed by 13 zero bits. An output with exponent field 0 always has a zero fraction.
- R4: An input with exponent 31 and fraction zero gives exponent 255 and fraction zero, with the input sign.
- R5: An input with exponent 31 and a nonzero fraction gives exponent 255 and a fraction made of the input fraction followed by 13 one bits.
- R6: Output bit 31 always equals bit 15 of the input word it came from.
- R7: A word taken at a clock edge makes `out_valid` high after that edge, with the converted value. Back-to-back words stream at one per cycle while `out_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_single` hold steady and `in_ready` is low.
- R9: A synchronous active-high `rst` makes `out_valid` low after the edge at which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_half | input | 16 | binary16 operand |
| out_valid | output | 1 | Converted word present |
| out_ready | input | 1 | Consumer takes the converted word this cycle |
| out_single | output | 32 | binary32 result |

## Verification
A fault in the leading-one encoder or the shifter would show as a wrong exponent or fraction for a subnormal input. It appears one cycle after that input is taken. Because all 65536 input codes are swept, every possible input is covered. A fault in the holding register shows either as a lost or duplicated word during a stall, or as `out_valid` staying high after reset. Either one is visible on the edge that follows.

// File: rtl/hs_fmt_pkg.sv
package hs_fmt_pkg;
  localparam int HALF_EXP_W = 5;
  localparam int HALF_MAN_W = 10;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_MAN_W  = 23;

  localparam int HALF_W    = 1 + HALF_EXP_W + HALF_MAN_W;
  localparam int SGL_W     = 1 + SGL_EXP_W + SGL_MAN_W;
  localparam int HALF_BIAS = (1 << (HALF_EXP_W - 1)) - 1;
  localparam int SGL_BIAS  = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int REBIAS    = SGL_BIAS - HALF_BIAS;
  localparam int PAD_W     = SGL_MAN_W - HALF_MAN_W;
  localparam int POS_W     = $clog2(HALF_MAN_W);
  localparam int SHAMT_W   = $clog2(HALF_MAN_W + 1);

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } hs_class_e;
endpackage

// File: rtl/hs_lead_one.sv
// Priority encoder: index of the most significant set bit.
module hs_lead_one #(
  parameter int W  = 10,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = PW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hs_shl.sv
// Logarithmic left shifter, one mux stage per amount bit.
module hs_shl #(
  parameter int W  = 10,
  parameter int SW = 4
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [SW+1];
  assign stg[0] = din;
  for (genvar g = 0; g < SW; g++) begin : g_stage
    assign stg[g+1] = amt[g] ? (stg[g] << (2 ** g)) : stg[g];
  end
  assign dout = stg[SW];
endmodule

// File: rtl/hs_widen_core.sv
// Combinational binary16 -> binary32 conversion.
module hs_widen_core
  import hs_fmt_pkg::*;
(
  input  logic [HALF_W-1:0] h_word,
  output logic [SGL_W-1:0]  s_word
);
  logic                  sgn;
  logic [HALF_EXP_W-1:0] h_exp;
  logic [HALF_MAN_W-1:0] h_man;
  logic [POS_W-1:0]      lead_pos;
  logic                  lead_found;
  logic [SHAMT_W-1:0]    shamt;
  logic [HALF_MAN_W-1:0] norm_man;
  hs_class_e             cls;
  logic [SGL_EXP_W-1:0]  o_exp;
  logic [SGL_MAN_W-1:0]  o_man;

  assign {sgn, h_exp, h_man} = h_word;

  hs_lead_one #(.W(HALF_MAN_W), .PW(POS_W)) u_lead (
    .vec   (h_man),
    .pos   (lead_pos),
    .found (lead_found)
  );

  assign shamt = SHAMT_W'(HALF_MAN_W) - SHAMT_W'(lead_pos);

  hs_shl #(.W(HALF_MAN_W), .SW(SHAMT_W)) u_shl (
    .din  (h_man),
    .amt  (shamt),
    .dout (norm_man)
  );

  always_comb begin
    if (h_exp == '0)       cls = lead_found ? CLS_SUB : CLS_ZERO;
    else if (&h_exp)       cls = (h_man != '0) ? CLS_NAN : CLS_INF;
    else                   cls = CLS_NORM;
  end

  always_comb begin
    unique case (cls)
      CLS_ZERO: begin
        o_exp = '0;
        o_man = '0;
      end
      CLS_SUB: begin
        o_exp = SGL_EXP_W'(REBIAS + 1) - SGL_EXP_W'(shamt);
        o_man = {norm_man, {PAD_W{1'b0}}};
      end
      CLS_INF: begin
        o_exp = '1;
        o_man = '0;
      end
      CLS_NAN: begin
        o_exp = '1;
        o_man = {h_man, {PAD_W{1'b1}}};
      end
      default: begin
        o_exp = SGL_EXP_W'(h_exp) + SGL_EXP_W'(REBIAS);
        o_man = {h_man, {PAD_W{1'b0}}};
      end
    endcase
  end

  assign s_word = {sgn, o_exp, o_man};
endmodule

// File: rtl/half_to_single_widen.sv
module half_to_single_widen
  import hs_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HALF_W-1:0] in_half,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SGL_W-1:0]  out_single
);
  logic [SGL_W-1:0] conv;

  hs_widen_core u_core (
    .h_word (in_half),
    .s_word (conv)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_single <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_single <= conv;
    end
  end
endmodule

// File: rtl/hs_widen_chk.sv
module hs_widen_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_sign,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_single
);
  // R7
  take_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_single)));

  // R8
  stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

  // R6
  sign_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_single[31] == $past(in_sign)));

  // R3
  no_sub_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_single[30:23] == 8'h00) |-> (out_single[22:0] == '0));

  // R5
  nan_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_single[30:23] == 8'hFF && out_single[22:0] != '0)
      |-> (out_single[12:0] == 13'h1FFF));

  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

bind half_to_single_widen hs_widen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sign    (in_half[15]),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_single (out_single)
);

// File: tb/tb_half_to_single_widen.sv
module tb_half_to_single_widen;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_half;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_single;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  half_to_single_widen dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_half    (in_half),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_single (out_single)
  );

  // {input, expected}
  localparam int NV = 16;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0000, 32'h00000000}, {16'h8000, 32'h80000000},
    {16'h3C00, 32'h3F800000}, {16'hBC00, 32'hBF800000},
    {16'h7BFF, 32'h477FE000}, {16'h0400, 32'h38800000},
    {16'h0001, 32'h33800000}, {16'h03FF, 32'h387FC000},
    {16'h8200, 32'hB8000000}, {16'h7C00, 32'h7F800000},
    {16'hFC00, 32'hFF800000}, {16'h7E00, 32'h7FC01FFF},
    {16'h7C01, 32'h7F803FFF}, {16'hFFFF, 32'hFFFFFFFF},
    {16'h0155, 32'h37AA8000}, {16'h3555, 32'h3EAAA000}
  };

  function automatic logic [31:0] model(input logic [15:0] h);
    logic [4:0]  e = h[14:10];
    logic [9:0]  f = h[9:0];
    logic [23:0] m;
    logic [7:0]  ex;
    if (e == 0 && f == 0) return {h[15], 31'd0};
    if (e == 5'd31) return {h[15], 8'hFF, (f == 0) ? 23'd0 : {f, 13'h1FFF}};
    if (e != 0) return {h[15], 8'(e) + 8'd112, f, 13'd0};
    m  = {1'b0, f, 13'd0};
    ex = 8'd113;
    for (int i = 0; i < 11; i++) begin
      if (!m[23]) begin
        m  = m << 1;
        ex = ex - 8'd1;
      end
    end
    return {h[15], ex, m[22:0]};
  endfunction

  function automatic string req_of(input logic [15:0] h);
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R4" : "R5";
    if (h[14:10] == 0) return (h[9:0] == 0) ? "R2" : "R3";
    return "R1";
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, want);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=%h exp=%h", 1'b0, 1'b1);
    finish_run();
  end

  initial begin
    logic [15:0] prev_h;
    logic [31:0] prev_exp;
    rst = 1'b1; in_valid = 1'b0; in_half = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    chk("R8 reset in_ready", 32'(in_ready), 32'd1);
    rst = 1'b0;

    // table walk, back to back (R1..R6, R7 streaming)
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R7 valid", 32'(out_valid), 32'd1);
        chk($sformatf("%s/R6 vec %h", req_of(prev_h), prev_h), out_single, prev_exp);
      end
      if (i < NV) begin
        in_valid = 1'b1;
        {prev_h, prev_exp} = VEC[i];
        in_half = prev_h;
      end else in_valid = 1'b0;
    end

    // exhaustive sweep
    for (int i = 0; i <= 65536; i++) begin
      @(negedge clk);
      if (i > 0) chk($sformatf("%s sweep %h", req_of(prev_h), prev_h), out_single, model(prev_h));
      if (i < 65536) begin
        in_valid = 1'b1;
        prev_h   = 16'(i);
        in_half  = prev_h;
      end else in_valid = 1'b0;
    end

    // R7: single word, valid for one cycle only
    @(negedge clk);
    chk("R7 idle", 32'(out_valid), 32'd0);
    in_valid = 1'b1; in_half = 16'h4000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 one-cycle latency", 32'(out_valid), 32'd1);
    chk("R1 value 2.0", out_single, 32'h40000000);
    @(negedge clk);
    chk("R7 drops after take", 32'(out_valid), 32'd0);

    // R8: back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_half = 16'h3C00;
    @(negedge clk);
    in_half = 16'h7C00;
    chk("R8 held valid", 32'(out_valid), 32'd1);
    chk("R8 in_ready low", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R8 held value", out_single, 32'h3F800000);
    chk("R8 still valid", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 next word after release", out_single, 32'h7F800000);
    @(negedge clk);
    chk("R8 drained", 32'(out_valid), 32'd0);

    // R9: reset while streaming
    in_valid = 1'b1; in_half = 16'h3C00;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset mid-stream", 32'(out_valid), 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 stays empty", 32'(out_valid), 32'd0);

    finish_run();
  end
endmodule